// File: doc/BRIEF.md
# Packed Lane Arithmetic Unit

The unit takes two 64-bit operands, a destination `dst` and a source `src`, and combines them lane by lane. The lane width comes from a mode input: two 32-bit lanes, four 16-bit lanes or eight 8-bit lanes. Within each lane it can add or subtract with wraparound, signed saturation or unsigned saturation. It can also compare two lanes for equality or for signed greater-than, which gives a mask of all ones or all zeros. Four bitwise operations act on the whole word and do not depend on the mode.

A request is one cycle with `req_valid` high. The result is registered and appears one cycle later with `res_valid` high. The unit refuses some combinations: an undefined operation code, the reserved mode, and saturating arithmetic on 32-bit lanes. For these it raises `illegal` together with `res_valid` and leaves `res` unchanged. The result register holds its value between requests.

Top module: `packed_alu`

## Requirements
- R1: After reset, `res` is zero and `res_valid` and `illegal` are low.
- R2: Wraparound add (op 0) and subtract (op 3) work modulo 2^lane-width in each lane. A carry or borrow never crosses into the next lane. Mode 0 gives 32-bit lanes, mode 1 gives 16-bit lanes and mode 2 gives 8-bit lanes, and lane 0 occupies the least significant bits.
- R3: Signed-saturating add (op 1) and subtract (op 4) clamp each lane to the most positive or most negative two's-complement value, for example 0x7F or 0x80 for bytes.
- R4: Unsigned-saturating add (op 2) clamps each lane at all ones. Unsigned-saturating subtract (op 5) clamps each lane at zero.
- R5: Any saturating operation (op 1, 2, 4 or 5) in mode 0 is refused. It sets `illegal`, and `res` keeps its previous value.
- R6: Equality compare (op 6) and signed greater-than compare (op 7, true when dst > src) write each lane as all ones when true and all zeros when false.
- R7: The bitwise operations act on all 64 bits in every mode, including mode 3: AND (op 8), AND-NOT (op 9, computing ~dst & src), OR (op 10) and XOR (op 11).
- R8: `res_valid` is high exactly one cycle after each request. In a cycle with no request, `res_valid` and `illegal` are low and `res` does not change.
- R9: Operation codes 12 to 15, and mode 3 with any operation other than a bitwise one, set `illegal` and leave `res` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| mode | input | 2 | Lane width: 0 = 2x32, 1 = 4x16, 2 = 8x8, 3 = reserved |
| op | input | 4 | Operation code |
| dst | input | 64 | Destination operand |
| src | input | 64 | Source operand |
| res_valid | output | 1 | Result valid, one cycle after a request |
| res | output | 64 | Registered result |
| illegal | output | 1 | The request was refused |

## Verification
The bench builds the unit with its default word width of 64. At that width all three lane widths exist side by side, so one word can hit the saturation boundaries at 0x7F/0x80, 0x7FFF/0x8000 and the all-ones and zero limits of the unsigned modes. Directed words place a carry or borrow right at a lane edge to show it does not cross into the next lane. Random words then cover all 16 operation codes and all four modes against a behavioural lane model.

// File: rtl/packed_alu.sv
module packed_alu #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        mode,
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  output logic              res_valid,
  output logic [DATA_W-1:0] res,
  output logic              illegal
);
  localparam int NWID = 3;
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADDS = 4'd1, OP_ADDU = 4'd2,
                         OP_SUB = 4'd3, OP_SUBS = 4'd4, OP_SUBU = 4'd5,
                         OP_EQ  = 4'd6, OP_GT   = 4'd7, OP_AND  = 4'd8,
                         OP_ANDN = 4'd9, OP_OR  = 4'd10, OP_XOR = 4'd11;

  logic [NWID-1:0][DATA_W-1:0] lane_out;
  logic [DATA_W-1:0] bw_res, nxt;
  logic is_bit, is_sat, legal;
  logic [1:0] sel;

  for (genvar g = 0; g < NWID; g++) begin : g_wid
    localparam int LW = 32 >> g;
    localparam int NL = DATA_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [LW-1:0] a, b, o;
      logic [LW:0]   sum, dif;
      logic          add_ovf, sub_ovf;
      logic [LW-1:0] smax, smin;
      assign a = dst[l*LW +: LW];
      assign b = src[l*LW +: LW];
      assign sum = {1'b0, a} + {1'b0, b};
      assign dif = {1'b0, a} - {1'b0, b};
      assign smax = {1'b0, {(LW-1){1'b1}}};
      assign smin = {1'b1, {(LW-1){1'b0}}};
      assign add_ovf = (a[LW-1] == b[LW-1]) && (sum[LW-1] != a[LW-1]);
      assign sub_ovf = (a[LW-1] != b[LW-1]) && (dif[LW-1] != a[LW-1]);
      always_comb begin
        case (op)
          OP_ADD:  o = sum[LW-1:0];
          OP_ADDS: o = add_ovf ? (a[LW-1] ? smin : smax) : sum[LW-1:0];
          OP_ADDU: o = sum[LW] ? {LW{1'b1}} : sum[LW-1:0];
          OP_SUB:  o = dif[LW-1:0];
          OP_SUBS: o = sub_ovf ? (a[LW-1] ? smin : smax) : dif[LW-1:0];
          OP_SUBU: o = dif[LW] ? '0 : dif[LW-1:0];
          OP_EQ:   o = {LW{a == b}};
          OP_GT:   o = {LW{$signed(a) > $signed(b)}};
          default: o = '0;
        endcase
      end
      assign lane_out[g][l*LW +: LW] = o;
    end
  end

  always_comb begin
    case (op)
      OP_AND:  bw_res = dst & src;
      OP_ANDN: bw_res = ~dst & src;
      OP_OR:   bw_res = dst | src;
      default: bw_res = dst ^ src;
    endcase
  end

  assign is_bit = (op >= OP_AND) && (op <= OP_XOR);
  assign is_sat = (op == OP_ADDS) || (op == OP_ADDU) || (op == OP_SUBS) || (op == OP_SUBU);
  assign legal  = is_bit || ((op <= OP_GT) && (mode != 2'd3) && !(is_sat && mode == 2'd0));
  assign sel    = (mode == 2'd3) ? 2'd2 : mode;
  assign nxt    = is_bit ? bw_res : lane_out[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      illegal   <= 1'b0;
      res       <= '0;
    end else begin
      res_valid <= req_valid;
      illegal   <= req_valid && !legal;
      if (req_valid && legal) res <= nxt;
    end
  end
endmodule

// File: rtl/packed_alu_chk.sv
module packed_alu_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        mode,
  input logic [3:0]        op,
  input logic [DATA_W-1:0] dst,
  input logic [DATA_W-1:0] src,
  input logic              res_valid,
  input logic [DATA_W-1:0] res,
  input logic              illegal
);
  logic bytes_mask_ok;
  always_comb begin
    bytes_mask_ok = 1'b1;
    for (int i = 0; i < DATA_W/8; i++)
      if (res[i*8 +: 8] != 8'h00 && res[i*8 +: 8] != 8'hFF) bytes_mask_ok = 1'b0;
  end

  // R8
  valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid && !illegal && $stable(res));
  // R5
  sat32_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && mode == 2'd0 && (op == 4'd1 || op == 4'd2 || op == 4'd4 || op == 4'd5)
      |=> illegal && $stable(res));
  // R7
  and_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && op == 4'd8 |=> !illegal && res == ($past(dst) & $past(src)));
  // R6
  byte_cmp_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && mode == 2'd2 && (op == 4'd6 || op == 4'd7) |=> bytes_mask_ok);
  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && op >= 4'd12 |=> illegal && $stable(res));
endmodule

bind packed_alu packed_alu_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .op(op),
  .dst(dst), .src(src), .res_valid(res_valid), .res(res), .illegal(illegal));

// File: tb/test_packed_alu.sv
module test_packed_alu;
  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [1:0] mode = '0;
  logic [3:0] op = '0;
  logic [63:0] dst = '0, src = '0;
  logic res_valid, illegal;
  logic [63:0] res;
  int total = 0, bad = 0;
  logic [63:0] exp_res = '0;
  logic exp_valid = 1'b0, exp_ill = 1'b0;

  always #5 clk = ~clk;

  packed_alu i_packed_alu (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .op(op), .dst(dst), .src(src), .res_valid(res_valid), .res(res), .illegal(illegal));

  function automatic void model(input logic [1:0] md, input logic [3:0] o,
                                input logic [63:0] d, input logic [63:0] s,
                                output bit ill, output logic [63:0] r);
    int lw;
    logic [63:0] mask;
    longint lim, ua, ub, sa, sb, t;
    r = '0;
    ill = 1'b0;
    if (o >= 8 && o <= 11) begin
      case (o)
        4'd8:    r = d & s;
        4'd9:    r = ~d & s;
        4'd10:   r = d | s;
        default: r = d ^ s;
      endcase
      return;
    end
    if (o > 7 || md == 3 || (md == 0 && (o == 1 || o == 2 || o == 4 || o == 5))) begin
      ill = 1'b1;
      return;
    end
    lw = (md == 0) ? 32 : (md == 1) ? 16 : 8;
    mask = (64'd1 << lw) - 64'd1;
    lim = longint'(1) <<< (lw - 1);
    for (int i = 0; i < 64 / lw; i++) begin
      ua = longint'((d >> (i * lw)) & mask);
      ub = longint'((s >> (i * lw)) & mask);
      sa = (ua >= lim) ? ua - 2 * lim : ua;
      sb = (ub >= lim) ? ub - 2 * lim : ub;
      case (o)
        4'd0: t = ua + ub;
        4'd3: t = ua - ub;
        4'd1, 4'd4: begin
          t = (o == 4'd1) ? sa + sb : sa - sb;
          if (t > lim - 1) t = lim - 1;
          if (t < -lim) t = -lim;
        end
        4'd2: begin t = ua + ub; if (t > longint'(mask)) t = longint'(mask); end
        4'd5: begin t = ua - ub; if (t < 0) t = 0; end
        4'd6: t = (ua == ub) ? longint'(mask) : 0;
        default: t = (sa > sb) ? longint'(mask) : 0;
      endcase
      r = r | ((64'(t) & mask) << (i * lw));
    end
  endfunction

  task automatic check(input string tag);
    total++;
    if (res_valid !== exp_valid || illegal !== exp_ill || res !== exp_res) begin
      bad++;
      $display("FAIL %s: got valid=%b ill=%b res=%h, expected valid=%b ill=%b res=%h",
               tag, res_valid, illegal, res, exp_valid, exp_ill, exp_res);
    end
  endtask

  task automatic step(input bit rq, input logic [1:0] md, input logic [3:0] o,
                      input logic [63:0] d, input logic [63:0] s, input string tag);
    bit ill;
    logic [63:0] r;
    @(negedge clk);
    req_valid = rq; mode = md; op = o; dst = d; src = s;
    if (rq) begin
      model(md, o, d, s, ill, r);
      exp_valid = 1'b1;
      exp_ill = ill;
      if (!ill) exp_res = r;
    end else begin
      exp_valid = 1'b0;
      exp_ill = 1'b0;
    end
    @(posedge clk);
    #1;
    check(tag);
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: got no end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    // R2 carries and borrows stop at lane edges
    step(1, 2'd1, 4'd0, 64'h0000_0000_0001_FFFF, 64'h0000_0000_0000_0001, "R2 16b add carry edge");
    step(1, 2'd2, 4'd3, 64'h0000_0000_0000_0100, 64'h0000_0000_0000_0001, "R2 8b sub borrow edge");
    step(1, 2'd0, 4'd0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0002, "R2 32b add wrap");
    // R3 signed saturation
    step(1, 2'd2, 4'd1, 64'h8080_7F7F_0000_807F, 64'h80FF_0101_0000_FF01, "R3 8b signed add clamp");
    step(1, 2'd1, 4'd4, 64'h7FFF_8000_0005_0000, 64'hFFFF_0001_0007_0000, "R3 16b signed sub clamp");
    // R4 unsigned saturation
    step(1, 2'd2, 4'd2, 64'h00FF_F0FF_0000_0010, 64'h0001_2001_0000_0020, "R4 8b unsigned add clamp");
    step(1, 2'd1, 4'd5, 64'h0010_FFFF_0001_0000, 64'h0020_0001_0001_0001, "R4 16b unsigned sub floor");
    // R5 saturation refused on 32-bit lanes
    step(1, 2'd0, 4'd1, 64'h1, 64'h1, "R5 32b signed add");
    step(1, 2'd0, 4'd5, 64'h1, 64'h1, "R5 32b unsigned sub");
    // R6 compares
    step(1, 2'd2, 4'd7, 64'h7F80_0102_0000_FF00, 64'h807F_0201_0000_00FF, "R6 8b signed greater");
    step(1, 2'd1, 4'd6, 64'h1234_5678_0000_FFFF, 64'h1234_5679_0000_FFFF, "R6 16b equal");
    step(1, 2'd0, 4'd7, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_0000_0000, "R6 32b signed greater");
    // R7 bitwise in every mode
    step(1, 2'd3, 4'd9, 64'hF0F0_1234_0000_FFFF, 64'hFFFF_FFFF_1111_0F0F, "R7 andnot mode3");
    step(1, 2'd0, 4'd10, 64'hF0F0_0000_0000_0001, 64'h0F0F_0000_0000_0002, "R7 or");
    step(1, 2'd2, 4'd11, 64'hAAAA_5555_0000_FFFF, 64'hFFFF_FFFF_0000_0F0F, "R7 xor");
    // R8 idle cycles hold
    step(0, 2'd1, 4'd0, 64'hFFFF, 64'hFFFF, "R8 idle hold");
    step(0, 2'd2, 4'd11, 64'h1, 64'h2, "R8 idle hold");
    // R9 undefined codes and reserved mode
    step(1, 2'd1, 4'd12, 64'h1, 64'h2, "R9 op 12");
    step(1, 2'd2, 4'd15, 64'h1, 64'h2, "R9 op 15");
    step(1, 2'd3, 4'd0, 64'h1, 64'h2, "R9 mode3 add");
    for (int k = 0; k < 600; k++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (k % 4 == 0) b = a;
      step(($urandom % 5) != 0, 2'($urandom), 4'($urandom), a, b,
           "R2 R3 R4 R5 R6 R7 R8 R9 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule